// File: doc/BRIEF.md
# Variable-Length Serial Converter Port

This block is the digital side of a serially accessed sampling converter. A host lowers chip-select and toggles an I/O clock. On each frame it shifts in an 8-bit control word, most significant bit first, and reads back the result of the previous conversion on the data output. The control word carries three things: a 4-bit input address in its first four bits, a 2-bit length code in bits five and six, and an order flag in bit seven. The length code decides how many clocks the frame itself lasts (8, 12 or 16). The frame therefore ends at a falling edge whose number is only known part-way through the frame.

The block raises a sample-enable toward the analog front end, with the input address on the channel select, from the fourth falling I/O clock edge to the last one. The last falling edge launches a conversion in a fixed-latency timer. That timer captures the `analog_code` input as the conversion result. The end-of-conversion flag drops a fixed number of system clocks later and rises again when the result is ready. At that rise, the result is packed into a 16-bit output word using the length and order of the frame that launched the conversion. The packing pads with zeros or drops low bits as the length requires. The word is sent from its first position at the start of every following frame. All serial inputs are sampled with the system clock, which must run several times faster than the I/O clock.

Top module: `vlp_top`

## Requirements
- R1: While reset is held and just after it, `eoc` is 1, `sample_en` is 0, `dout` is 0 and `chan_sel` is 0.
- R2: The 5th and 6th control bits received form the length code. Code 01 makes the frame 8 clocks long, code 11 makes it 16, and codes 00 or 10 make it 12. The frame ends on that falling edge, and every further I/O clock edge is ignored until chip-select goes high.
- R3: In MSB-first order, a 12-clock frame sends result bits 11 down to 0. MSB-first data is correct whatever the length of the reading frame.
- R4: A result packed for 16 bits in MSB-first order is sent as its 12 bits followed by four zero bits.
- R5: A result packed for 8 bits is sent as its upper 8 bits only. Bits 3..0 are dropped.
- R6: When control bit 7 is 1, the packed word goes out least significant bit first. For a 16-bit packing, the four zero pads come first. Packing uses the length and order of the frame that launched the conversion, so a length change under LSB-first order can corrupt that one result.
- R7: `sample_en` rises on the 4th falling I/O clock edge, with `chan_sel` equal to the first four control bits. It falls on the frame's last falling edge. `chan_sel` changes only when sampling starts.
- R8: `eoc` falls EOC_DLY system clocks after the edge on which the frame's last falling I/O edge is taken. It rises CONV_CYC clocks after that, with the captured `analog_code` becoming the next result at the same time.
- R9: Raising chip-select mid-frame drops `sample_en` and starts no conversion. The next frame counts from bit one and resends the same result.
- R10: Outside a frame (chip-select high) `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip-select |
| io_clk | input | 1 | Serial I/O clock |
| din | input | 1 | Serial control input |
| analog_code | input | 12 | Stand-in for the sampled input value |
| dout | output | 1 | Serial result output |
| sample_en | output | 1 | Sampling window toward the front end |
| chan_sel | output | 4 | Input address toward the front end |
| eoc | output | 1 | End of conversion, low while converting |

## Verification
A vector table chains frames in which length and order change from one frame to the next. This exercises the case where the word was packed for one length and is read in another. A design that took its packing from the reading frame, or padded on the wrong side, would send wrong bits there. Directed tests target three more cases:
- An abort after five clocks, where a wrong design would still convert or lose its bit count.
- Extra clocks after the frame has ended, where a wrong design would start a second frame or conversion.
- The exact EOC delay and conversion length, where off-by-one counters show up.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  localparam int RES_W  = 12;
  localparam int WORD_W = 16;
  localparam int CH_W   = 4;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  // clocks in a frame for a length code
  function automatic logic [CNT_W-1:0] frame_bits(input logic [1:0] code);
    case (code)
      2'b01:   return CNT_W'(8);
      2'b11:   return CNT_W'(16);
      default: return CNT_W'(12);
    endcase
  endfunction

  // word sent from bit WORD_W-1 downward
  function automatic logic [WORD_W-1:0] pack_word(input logic [RES_W-1:0] r,
                                                  input logic [1:0] code,
                                                  input logic lsb);
    logic [WORD_W-1:0] w;
    w = '0;
    if (!lsb) begin
      w = {r, 4'b0000};
    end else begin
      case (code)
        2'b01: for (int i = 0; i < 8; i++) w[WORD_W-1-i] = r[4+i];
        2'b11: for (int i = 0; i < RES_W; i++) w[RES_W-1-i] = r[i];
        default: for (int i = 0; i < RES_W; i++) w[WORD_W-1-i] = r[i];
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/vlp_edge.sv
module vlp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic io_clk,
  output logic sel,
  output logic rise_ev,
  output logic fall_ev,
  output logic frame_open
);
  logic cs_q, io_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
      io_q <= 1'b0;
    end else begin
      cs_q <= cs_n;
      io_q <= io_clk;
    end
  end

  assign sel        = ~cs_q;
  assign rise_ev    = sel & io_clk & ~io_q;
  assign fall_ev    = sel & ~io_clk & io_q;
  assign frame_open = cs_q & ~cs_n;
endmodule

// File: rtl/vlp_ctrl.sv
module vlp_ctrl
  import vlp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            rise_ev,
  input  logic            fall_ev,
  input  logic            din,
  output logic [CH_W-1:0] addr,
  output logic [1:0]      len_code,
  output logic            lsb_first,
  output logic            fall_acc,
  output logic            sample_start,
  output logic            frame_end
);
  logic [CNT_W-1:0] rise_cnt, fall_cnt;
  logic [2:0]       sr;
  logic             locked;
  logic             rise_acc;

  assign rise_acc     = rise_ev & ~locked;
  assign fall_acc     = fall_ev & ~locked;
  assign sample_start = fall_acc & (fall_cnt == CNT_W'(3));
  assign frame_end    = fall_acc & ((fall_cnt + CNT_W'(1)) == frame_bits(len_code));

  always_ff @(posedge clk) begin
    if (!rst_n || !sel) begin
      rise_cnt  <= '0;
      fall_cnt  <= '0;
      sr        <= '0;
      locked    <= 1'b0;
      len_code  <= 2'b11;
      lsb_first <= 1'b0;
      if (!rst_n) addr <= '0;
    end else begin
      if (rise_acc) begin
        sr       <= {sr[1:0], din};
        rise_cnt <= rise_cnt + CNT_W'(1);
        if (rise_cnt == CNT_W'(3)) addr      <= {sr, din};
        if (rise_cnt == CNT_W'(5)) len_code  <= {sr[0], din};
        if (rise_cnt == CNT_W'(6)) lsb_first <= din;
      end
      if (fall_acc) begin
        fall_cnt <= fall_cnt + CNT_W'(1);
        if (frame_end) locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vlp_timer.sv
module vlp_timer
  import vlp_pkg::*;
#(
  parameter int EOC_DLY  = 3,
  parameter int CONV_CYC = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RES_W-1:0] sample_val,
  output logic             eoc,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam int MAXC = (EOC_DLY > CONV_CYC) ? EOC_DLY : CONV_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {T_IDLE, T_DLY, T_CONV} tstate_t;
  tstate_t          st;
  logic [CW-1:0]    cnt;
  logic [RES_W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= T_IDLE;
      cnt    <= '0;
      held   <= '0;
      result <= '0;
      eoc    <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st   <= T_DLY;
        cnt  <= CW'(EOC_DLY - 1);
        held <= sample_val;
      end else begin
        case (st)
          T_DLY: begin
            if (cnt == '0) begin
              eoc <= 1'b0;
              cnt <= CW'(CONV_CYC - 1);
              st  <= T_CONV;
            end else begin
              cnt <= cnt - CW'(1);
            end
          end
          T_CONV: begin
            if (cnt == '0) begin
              eoc    <= 1'b1;
              done   <= 1'b1;
              result <= held;
              st     <= T_IDLE;
            end else begin
              cnt <= cnt - CW'(1);
            end
          end
          default: st <= T_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/vlp_out.sv
module vlp_out
  import vlp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              frame_open,
  input  logic              shift,
  input  logic              capture,
  input  logic [WORD_W-1:0] word,
  output logic              dout
);
  logic [WORD_W-1:0] res_word, out_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_word <= '0;
      out_sr   <= '0;
    end else begin
      if (capture) res_word <= word;
      if (frame_open)  out_sr <= res_word;
      else if (shift)  out_sr <= {out_sr[WORD_W-2:0], 1'b0};
    end
  end

  assign dout = sel & out_sr[WORD_W-1];
endmodule

// File: rtl/vlp_top.sv
module vlp_top
  import vlp_pkg::*;
#(
  parameter int EOC_DLY  = 3,
  parameter int CONV_CYC = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             io_clk,
  input  logic             din,
  input  logic [RES_W-1:0] analog_code,
  output logic             dout,
  output logic             sample_en,
  output logic [CH_W-1:0]  chan_sel,
  output logic             eoc
);
  logic             sel, rise_ev, fall_ev, frame_open;
  logic [CH_W-1:0]  addr;
  logic [1:0]       len_code, conv_len;
  logic             lsb_first, conv_lsb;
  logic             fall_acc, sample_start, frame_end;
  logic             conv_done;
  logic [RES_W-1:0] conv_result;
  logic [WORD_W-1:0] packed_w;

  vlp_edge edge_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io_clk(io_clk),
    .sel(sel), .rise_ev(rise_ev), .fall_ev(fall_ev), .frame_open(frame_open)
  );

  vlp_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .din(din), .addr(addr), .len_code(len_code), .lsb_first(lsb_first),
    .fall_acc(fall_acc), .sample_start(sample_start), .frame_end(frame_end)
  );

  vlp_timer #(.EOC_DLY(EOC_DLY), .CONV_CYC(CONV_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(frame_end), .sample_val(analog_code),
    .eoc(eoc), .done(conv_done), .result(conv_result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_en <= 1'b0;
      chan_sel  <= '0;
      conv_len  <= 2'b00;
      conv_lsb  <= 1'b0;
    end else begin
      if (!sel || frame_end) sample_en <= 1'b0;
      else if (sample_start) sample_en <= 1'b1;
      if (sample_start) chan_sel <= addr;
      if (frame_end) begin
        conv_len <= len_code;
        conv_lsb <= lsb_first;
      end
    end
  end

  assign packed_w = pack_word(conv_result, conv_len, conv_lsb);

  vlp_out out_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .frame_open(frame_open),
    .shift(fall_acc), .capture(conv_done), .word(packed_w), .dout(dout)
  );
endmodule

// File: rtl/vlp_chk.sv
module vlp_chk
  import vlp_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            sample_en,
  input logic            eoc,
  input logic [CH_W-1:0] chan_sel,
  input logic            sample_start,
  input logic            frame_end,
  input logic            conv_done
);
  // R7
  samp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_en) |-> $past(sample_start));
  // R7
  samp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !sample_en);
  // R7
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_start |=> $stable(chan_sel));
  // R9
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ##1 !sample_en);
  // R8
  eoc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> conv_done);
  // R8
  conv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> !sample_en);
endmodule

bind vlp_top vlp_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sample_en(sample_en), .eoc(eoc),
  .chan_sel(chan_sel), .sample_start(sample_start), .frame_end(frame_end),
  .conv_done(conv_done)
);

// File: tb/vlp_top_tb.sv
module vlp_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int EOC_DLY    = 3;
  localparam int CONV_CYC   = 20;
  localparam int NVEC       = 9;

  // {addr[3:0], len code[1:0], lsb flag, analog[11:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {4'd3,  2'b00, 1'b0, 12'hA5C},
    {4'd7,  2'b11, 1'b0, 12'h3F1},
    {4'd12, 2'b01, 1'b0, 12'hC3A},
    {4'd1,  2'b10, 1'b1, 12'h5E7},
    {4'd9,  2'b10, 1'b1, 12'h9B2},
    {4'd4,  2'b11, 1'b1, 12'h6D4},
    {4'd15, 2'b01, 1'b1, 12'hE18},
    {4'd2,  2'b01, 1'b0, 12'h0FF},
    {4'd0,  2'b00, 1'b0, 12'h800}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        io_clk = 1'b0;
  logic        din = 1'b0;
  logic [11:0] analog_code = '0;
  logic        dout, sample_en, eoc;
  logic [3:0]  chan_sel;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [11:0] prev_r;
  logic [1:0]  prev_code;
  logic        prev_lsb;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlp_top #(.EOC_DLY(EOC_DLY), .CONV_CYC(CONV_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io_clk(io_clk), .din(din),
    .analog_code(analog_code), .dout(dout), .sample_en(sample_en),
    .chan_sel(chan_sel), .eoc(eoc)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] code);
    if (code == 2'b01) return 8;
    if (code == 2'b11) return 16;
    return 12;
  endfunction

  function automatic logic exp_bit(input logic [11:0] r, input logic [1:0] code,
                                   input logic lsb, input int k);
    logic [15:0] v;
    int w;
    if (!lsb) return (k < 12) ? r[11-k] : 1'b0;
    w = width_of(code);
    if (w == 8) v = {8'b0, r[11:4]};
    else if (w == 16) v = {r, 4'b0};
    else v = {4'b0, r};
    return (k < w) ? v[k] : 1'b0;
  endfunction

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one full frame; checks data, sampling window and EOC timing
  task automatic run_frame(input logic [3:0] addr, input logic [1:0] code,
                           input logic lsb, input logic [11:0] analog);
    logic [7:0] ctl;
    int n, nclk, cnt;
    string tag;
    ctl  = {addr, code, lsb, 1'b0};
    nclk = width_of(code);
    if (prev_lsb) tag = "R6";
    else if (nclk == 16) tag = "R4";
    else if (nclk == 8) tag = "R5";
    else tag = "R3";
    analog_code = analog;
    @(negedge clk);
    cs_n = 1'b0;
    wait_neg(HALF);
    check(tag, {15'b0, dout}, {15'b0, exp_bit(prev_r, prev_code, prev_lsb, 0)});
    for (int k = 1; k <= nclk; k++) begin
      din = (k <= 8) ? ctl[8-k] : 1'b0;
      io_clk = 1'b1;
      wait_neg(HALF);
      io_clk = 1'b0;
      if (k < nclk) begin
        wait_neg(HALF);
        check(tag, {15'b0, dout}, {15'b0, exp_bit(prev_r, prev_code, prev_lsb, k)});
        check("R7", {15'b0, sample_en}, {15'b0, (k >= 4)});
        if (k == 4) check("R7", {12'b0, chan_sel}, {12'b0, addr});
        if (k == 7) check("R2", {15'b0, eoc}, 16'd1);
      end
    end
    cnt = 0;
    while (eoc !== 1'b0 && cnt < 100) begin @(negedge clk); cnt++; end
    check("R8", 16'(cnt), 16'(EOC_DLY + 1));
    check("R2", {15'b0, sample_en}, 16'd0);
    n = 0;
    while (eoc !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    check("R8", 16'(n), 16'(CONV_CYC));
    cs_n = 1'b1;
    din = 1'b0;
    wait_neg(HALF);
    check("R10", {15'b0, dout}, 16'd0);
    prev_r = analog;
    prev_code = code;
    prev_lsb = lsb;
  endtask

  initial begin
    prev_r = '0; prev_code = 2'b00; prev_lsb = 1'b0;
    wait_neg(5);
    // reset state
    check("R1", {15'b0, eoc}, 16'd1);
    check("R1", {15'b0, sample_en}, 16'd0);
    check("R1", {15'b0, dout}, 16'd0);
    check("R1", {12'b0, chan_sel}, 16'd0);
    rst_n = 1'b1;
    wait_neg(3);
    check("R1", {15'b0, eoc}, 16'd1);

    for (int v = 0; v < NVEC; v++)
      run_frame(VEC[v][18:15], VEC[v][14:13], VEC[v][12], VEC[v][11:0]);

    // R9: abort after five clocks
    @(negedge clk);
    cs_n = 1'b0;
    wait_neg(HALF);
    for (int k = 1; k <= 5; k++) begin
      din = 1'b1;
      io_clk = 1'b1; wait_neg(HALF);
      io_clk = 1'b0; wait_neg(HALF);
    end
    check("R9", {15'b0, sample_en}, 16'd1);
    cs_n = 1'b1;
    din = 1'b0;
    wait_neg(3);
    check("R9", {15'b0, sample_en}, 16'd0);
    begin
      int low_seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (eoc !== 1'b1) low_seen++;
      end
      check("R9", 16'(low_seen), 16'd0);
    end
    // resends same result, counting from bit one
    run_frame(4'd6, 2'b00, 1'b0, 12'h321);

    // R2: edges after frame end ignored
    @(negedge clk);
    cs_n = 1'b0;
    wait_neg(HALF);
    for (int k = 1; k <= 8; k++) begin
      din = (k == 6) ? 1'b1 : 1'b0;
      io_clk = 1'b1; wait_neg(HALF);
      io_clk = 1'b0; wait_neg(HALF);
    end
    begin
      int w = 0;
      while (eoc !== 1'b1 && w < 200) begin @(negedge clk); w++; end
    end
    for (int k = 1; k <= 6; k++) begin
      io_clk = 1'b1; wait_neg(HALF);
      io_clk = 1'b0; wait_neg(HALF);
      check("R2", {14'b0, sample_en, eoc}, 16'd1);
    end
    cs_n = 1'b1;
    wait_neg(HALF);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule